// File: doc/BRIEF.md
# Regional Curvature-Azimuth Vote Histogram

This block collects track-segment votes for one azimuthal slice of a drift-chamber trigger. Each cycle, up to `NUM_IN` segment lanes may each present a curvature bin and a local azimuth bin. Every valid, in-range segment adds one vote to the matching cell of a 16 x 10 grid of saturating counters. A lane whose coordinates fall outside the grid is discarded, and a cumulative error counter records it.

A one-cycle crossing strobe marks the last cycle of a bunch crossing. On that edge the grid, including the votes that arrive in the strobe cycle, is copied into a frozen readout image. The live grid restarts from zero, so votes arriving in the very next cycle open the next crossing. The frozen image is held for the downstream decision stage until the next strobe.

The two edge azimuth columns of the frozen image are driven onto a ring link to the neighbouring slices. The matching columns that the neighbours drive back are latched one cycle later. This lets six slices of ten azimuth bins be tiled into the full 16 x 60 map.

Top module: `kpHistTop`

## Requirements
- R1: After reset, `histOut`, `edgeLoOut`, `edgeHiOut`, `haloLo`, `haloHi` and `errCount` are zero, and `histValid` and `haloValid` are low.
- R2: A lane with `segValid` high and in-range coordinates adds one vote to cell (k, p). In `histOut` that cell occupies bits `[(k*10+p)*CNT_W +: CNT_W]`. Lane i uses kappa bits `[i*5 +: 5]` and phi bits `[i*5 +: 5]`.
- R3: Votes from several lanes that address the same cell in the same cycle are all counted.
- R4: A cell counter saturates at 2^CNT_W-1 (15 by default) and never wraps.
- R5: The frozen image contains every vote up to and including the strobe cycle. `histOut` changes and `histValid` pulses high for one cycle at the edge after the strobe cycle. Votes in the following cycle, including a back-to-back strobe, belong only to the next crossing.
- R6: `histOut` holds its value in every cycle without a strobe.
- R7: A lane with `segValid` high and kappa >= 16 or phi >= 10 changes no cell. It raises `errCount` by one in that cycle's update. `errCount` saturates at 255 and is cleared only by reset.
- R8: `edgeLoOut` carries the frozen phi-0 column and `edgeHiOut` the frozen phi-9 column, with kappa k at bits `[k*CNT_W +: CNT_W]`.
- R9: `nbrLoIn` and `nbrHiIn` are latched into `haloLo` and `haloHi` at the edge that follows the cycle in which `histValid` is high. `haloValid` pulses with that update, and both halo registers hold otherwise.
- R10: A lane with `segValid` low changes neither any cell nor `errCount`, whatever its coordinates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| segValid | input | NUM_IN | Per-lane segment valid |
| segKappa | input | NUM_IN*5 | Per-lane curvature bin |
| segPhi | input | NUM_IN*5 | Per-lane local azimuth bin |
| bxStrobe | input | 1 | Last cycle of a bunch crossing |
| nbrLoIn | input | 16*CNT_W | Edge column from the lower neighbour |
| nbrHiIn | input | 16*CNT_W | Edge column from the upper neighbour |
| histOut | output | 160*CNT_W | Frozen histogram image |
| histValid | output | 1 | New frozen image present |
| edgeLoOut | output | 16*CNT_W | Frozen phi-0 column to the ring |
| edgeHiOut | output | 16*CNT_W | Frozen phi-9 column to the ring |
| haloLo | output | 16*CNT_W | Latched lower neighbour column |
| haloHi | output | 16*CNT_W | Latched upper neighbour column |
| haloValid | output | 1 | Halo columns just updated |
| errCount | output | ERR_W | Saturating count of dropped segments |

## Verification
Two functions can coincide in one cycle: a vote landing in a cell, and the crossing strobe that freezes and clears that same cell. The bench drives votes in the strobe cycle itself. It also drives votes in the cycle right after a strobe, and once issues two strobes back to back. The frozen image must include the strobe-cycle votes, and the second image must contain only the votes from the cycle between the two strobes. A second collision is two lanes striking one cell in the same cycle, both below and at saturation. A bench model that applies each vote in turn judges every cell.

// File: rtl/kpHistPkg.sv
package kpHistPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic freeze;       // copy live grid to readout image, restart live grid
    logic captureHalo;  // latch neighbour edge columns
  } kpStrobe_t;
endpackage

// File: rtl/kpHistCtrl.sv
module kpHistCtrl
  import kpHistPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bxStrobe,
  output kpStrobe_t stb,
  output logic      histValid,
  output logic      haloValid
);
  assign stb.freeze      = bxStrobe;
  assign stb.captureHalo = histValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histValid <= 1'b0;
      haloValid <= 1'b0;
    end else begin
      histValid <= bxStrobe;
      haloValid <= histValid;
    end
  end

  assert_valid_after_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    bxStrobe |=> histValid);
  assert_halo_follows_image_R9: assert property (@(posedge clk) disable iff (!rstN)
    histValid |=> haloValid);
endmodule

// File: rtl/kpHistData.sv
module kpHistData
  import kpHistPkg::*;
#(
  parameter int NUM_IN     = 2,
  parameter int KAPPA_BINS = 16,
  parameter int PHI_BINS   = 10,
  parameter int CNT_W      = 4,
  parameter int ERR_W      = 8,
  parameter int KIN_W      = 5,
  parameter int PIN_W      = 5
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  kpStrobe_t                        stb,
  input  logic [NUM_IN-1:0]                segValid,
  input  logic [NUM_IN*KIN_W-1:0]          segKappa,
  input  logic [NUM_IN*PIN_W-1:0]          segPhi,
  input  logic [KAPPA_BINS*CNT_W-1:0]      nbrLoIn,
  input  logic [KAPPA_BINS*CNT_W-1:0]      nbrHiIn,
  output logic [KAPPA_BINS*PHI_BINS*CNT_W-1:0] histOut,
  output logic [KAPPA_BINS*CNT_W-1:0]      edgeLoOut,
  output logic [KAPPA_BINS*CNT_W-1:0]      edgeHiOut,
  output logic [KAPPA_BINS*CNT_W-1:0]      haloLo,
  output logic [KAPPA_BINS*CNT_W-1:0]      haloHi,
  output logic [ERR_W-1:0]                 errCount
);
  localparam int NCELL = KAPPA_BINS * PHI_BINS;
  localparam int IW    = $clog2(NUM_IN + 1);
  localparam int SW    = CNT_W + IW;
  localparam int EW    = ERR_W + IW;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [ERR_W-1:0] EMAX = '1;
  localparam logic [KIN_W-1:0] KLIM = KIN_W'(KAPPA_BINS);
  localparam logic [PIN_W-1:0] PLIM = PIN_W'(PHI_BINS);

  logic [KIN_W-1:0] laneK [NUM_IN];
  logic [PIN_W-1:0] laneP [NUM_IN];
  logic [NUM_IN-1:0] laneOk, laneBad;
  logic [CNT_W-1:0] live [NCELL];
  logic [CNT_W-1:0] snap [NCELL];

  // Lane decode and range check
  for (genvar i = 0; i < NUM_IN; i++) begin : gLane
    assign laneK[i]   = segKappa[i*KIN_W +: KIN_W];
    assign laneP[i]   = segPhi[i*PIN_W +: PIN_W];
    assign laneOk[i]  = segValid[i] && (laneK[i] < KLIM) && (laneP[i] < PLIM);
    assign laneBad[i] = segValid[i] && !laneOk[i];
  end

  // Vote cells: count all lanes hitting the cell, saturate, freeze and restart
  for (genvar c = 0; c < NCELL; c++) begin : gCell
    localparam logic [KIN_W-1:0] KC = KIN_W'(c / PHI_BINS);
    localparam logic [PIN_W-1:0] PC = PIN_W'(c % PHI_BINS);
    logic [IW-1:0]    hits;
    logic [SW-1:0]    sum;
    logic [CNT_W-1:0] nxt;

    always_comb begin
      hits = '0;
      for (int i = 0; i < NUM_IN; i++)
        if (laneOk[i] && laneK[i] == KC && laneP[i] == PC) hits = hits + IW'(1);
      sum = SW'(live[c]) + SW'(hits);
      nxt = (sum > SW'(CMAX)) ? CMAX : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        live[c] <= '0;
        snap[c] <= '0;
      end else if (stb.freeze) begin
        live[c] <= '0;
        snap[c] <= nxt;
      end else begin
        live[c] <= nxt;
      end
    end

    assign histOut[c*CNT_W +: CNT_W] = snap[c];

    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
      !stb.freeze |=> live[c] >= $past(live[c]));
    assert_image_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      !stb.freeze |=> $stable(snap[c]));
  end

  // Ring edge columns
  for (genvar k = 0; k < KAPPA_BINS; k++) begin : gEdge
    assign edgeLoOut[k*CNT_W +: CNT_W] = snap[k*PHI_BINS];
    assign edgeHiOut[k*CNT_W +: CNT_W] = snap[k*PHI_BINS + PHI_BINS - 1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haloLo <= '0;
      haloHi <= '0;
    end else if (stb.captureHalo) begin
      haloLo <= nbrLoIn;
      haloHi <= nbrHiIn;
    end
  end

  // Dropped-segment counter
  logic [EW-1:0] errSum;
  always_comb errSum = EW'(errCount) + EW'($countones(laneBad));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  errCount <= '0;
    else if (errSum > EW'(EMAX)) errCount <= EMAX;
    else                        errCount <= errSum[ERR_W-1:0];
  end

  assert_err_monotonic_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> errCount >= $past(errCount));
  assert_halo_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.captureHalo |=> ($stable(haloLo) && $stable(haloHi)));
endmodule

// File: rtl/kpHistTop.sv
module kpHistTop
  import kpHistPkg::*;
#(
  parameter int NUM_IN     = 2,
  parameter int KAPPA_BINS = 16,
  parameter int PHI_BINS   = 10,
  parameter int CNT_W      = 4,
  parameter int ERR_W      = 8,
  localparam int KIN_W     = $clog2(KAPPA_BINS) + 1,
  localparam int PIN_W     = $clog2(PHI_BINS) + 1,
  localparam int COL_W     = KAPPA_BINS * CNT_W,
  localparam int HIST_W    = KAPPA_BINS * PHI_BINS * CNT_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_IN-1:0]       segValid,
  input  logic [NUM_IN*KIN_W-1:0] segKappa,
  input  logic [NUM_IN*PIN_W-1:0] segPhi,
  input  logic                    bxStrobe,
  input  logic [COL_W-1:0]        nbrLoIn,
  input  logic [COL_W-1:0]        nbrHiIn,
  output logic [HIST_W-1:0]       histOut,
  output logic                    histValid,
  output logic [COL_W-1:0]        edgeLoOut,
  output logic [COL_W-1:0]        edgeHiOut,
  output logic [COL_W-1:0]        haloLo,
  output logic [COL_W-1:0]        haloHi,
  output logic                    haloValid,
  output logic [ERR_W-1:0]        errCount
);
  kpStrobe_t stb;

  kpHistCtrl uCtrl (
    .clk(clk), .rstN(rstN), .bxStrobe(bxStrobe),
    .stb(stb), .histValid(histValid), .haloValid(haloValid)
  );

  kpHistData #(
    .NUM_IN(NUM_IN), .KAPPA_BINS(KAPPA_BINS), .PHI_BINS(PHI_BINS),
    .CNT_W(CNT_W), .ERR_W(ERR_W), .KIN_W(KIN_W), .PIN_W(PIN_W)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .segValid(segValid), .segKappa(segKappa), .segPhi(segPhi),
    .nbrLoIn(nbrLoIn), .nbrHiIn(nbrHiIn),
    .histOut(histOut), .edgeLoOut(edgeLoOut), .edgeHiOut(edgeHiOut),
    .haloLo(haloLo), .haloHi(haloHi), .errCount(errCount)
  );
endmodule

// File: tb/tb_kpHistTop.sv
`timescale 1ns/1ps
module tb_kpHistTop;
  localparam int NCELL = 160;
  localparam int CMAXV = 15;
  localparam int EMAXV = 255;
  localparam realtime CLK_P = 8ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] segValid = '0;
  logic [9:0] segKappa = '0;
  logic [9:0] segPhi = '0;
  logic bxStrobe = 1'b0;
  logic [63:0] nbrLoIn = '0, nbrHiIn = '0;
  logic [639:0] histOut;
  logic histValid, haloValid;
  logic [63:0] edgeLoOut, edgeHiOut, haloLo, haloHi;
  logic [7:0] errCount;

  kpHistTop dut (
    .clk(clk), .rstN(rstN), .segValid(segValid), .segKappa(segKappa), .segPhi(segPhi),
    .bxStrobe(bxStrobe), .nbrLoIn(nbrLoIn), .nbrHiIn(nbrHiIn), .histOut(histOut),
    .histValid(histValid), .edgeLoOut(edgeLoOut), .edgeHiOut(edgeHiOut),
    .haloLo(haloLo), .haloHi(haloHi), .haloValid(haloValid), .errCount(errCount)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  int liveM [NCELL];
  int snapM [NCELL];
  int errM = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic modelHit(int k, int p);
    if (k < 16 && p < 10) begin
      if (liveM[k*10+p] < CMAXV) liveM[k*10+p]++;
    end else if (errM < EMAXV) errM++;
  endtask

  // Drive one cycle right after a falling edge, update the model, wait for the next falling edge
  task automatic step(bit v0, int k0, int p0, bit v1, int k1, int p1, bit strobe);
    segValid = {v1, v0};
    segKappa = {5'(k1), 5'(k0)};
    segPhi   = {5'(p1), 5'(p0)};
    bxStrobe = strobe;
    if (v0) modelHit(k0, p0);
    if (v1) modelHit(k1, p1);
    if (strobe)
      for (int c = 0; c < NCELL; c++) begin snapM[c] = liveM[c]; liveM[c] = 0; end
    @(negedge clk);
  endtask

  task automatic idle(bit strobe);
    step(0, 0, 0, 0, 0, 0, strobe);
  endtask

  task automatic checkHist(string req, string what);
    int bad = -1;
    for (int c = 0; c < NCELL; c++)
      if (bad < 0 && int'(histOut[c*4 +: 4]) != snapM[c]) bad = c;
    if (bad < 0) check(1, req, what, 0, 0);
    else check(0, req, $sformatf("%s cell %0d", what, bad), histOut[bad*4 +: 4], snapM[bad]);
  endtask

  task automatic checkEdges(string req);
    logic [63:0] lo, hi;
    for (int k = 0; k < 16; k++) begin
      lo[k*4 +: 4] = 4'(snapM[k*10]);
      hi[k*4 +: 4] = 4'(snapM[k*10+9]);
    end
    check(edgeLoOut == lo, req, "edgeLoOut", edgeLoOut, lo);
    check(edgeHiOut == hi, req, "edgeHiOut", edgeHiOut, hi);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCELL; c++) begin liveM[c] = 0; snapM[c] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(histOut == '0, "R1", "histOut", 0, 0);
    check(!histValid && !haloValid, "R1", "valid flags", {histValid, haloValid}, 0);
    check(errCount == 0 && haloLo == 0 && haloHi == 0, "R1", "err/halo", errCount, 0);
    check(edgeLoOut == 0 && edgeHiOut == 0, "R1", "edges", edgeLoOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R8/R5: sweep every cell once on lane 0, second lane on every third cycle
    for (int c = 0; c < NCELL; c++)
      step(1, c / 10, c % 10, (c % 3) == 0, 15 - c / 10, 9 - c % 10, c == NCELL - 1);
    check(histValid == 1'b1, "R5", "histValid after strobe", histValid, 1);
    checkHist("R2", "full sweep image");
    checkEdges("R8");

    // R9: neighbours present columns while histValid is high
    nbrLoIn = 64'h0123_4567_89AB_CDEF;
    nbrHiIn = 64'hFEDC_BA98_7654_3210;
    idle(0);
    check(histValid == 1'b0, "R5", "histValid single pulse", histValid, 0);
    check(haloValid == 1'b1, "R9", "haloValid", haloValid, 1);
    check(haloLo == 64'h0123_4567_89AB_CDEF, "R9", "haloLo", haloLo, 64'h0123_4567_89AB_CDEF);
    check(haloHi == 64'hFEDC_BA98_7654_3210, "R9", "haloHi", haloHi, 64'hFEDC_BA98_7654_3210);
    nbrLoIn = 64'h5555_5555_5555_5555;
    nbrHiIn = 64'hAAAA_AAAA_AAAA_AAAA;
    idle(0);
    check(haloValid == 1'b0, "R9", "haloValid drop", haloValid, 0);
    check(haloLo == 64'h0123_4567_89AB_CDEF, "R9", "haloLo hold", haloLo, 64'h0123_4567_89AB_CDEF);
    checkHist("R6", "image hold without strobe");

    // R3: both lanes on one cell for three cycles, strobe in the last one
    step(1, 3, 4, 1, 3, 4, 0);
    step(1, 3, 4, 1, 3, 4, 0);
    checkHist("R6", "image hold while voting");
    step(1, 3, 4, 1, 3, 4, 1);
    check(histOut[34*4 +: 4] == 4'd6, "R3", "same-cell votes", histOut[34*4 +: 4], 6);
    checkHist("R3", "same-cell image");
    // R5: back-to-back strobe holds only the single cycle between
    step(1, 0, 0, 0, 0, 0, 1);
    check(histValid == 1'b1, "R5", "back-to-back histValid", histValid, 1);
    checkHist("R5", "back-to-back image");

    // R5: votes right after a strobe open the next crossing
    step(1, 5, 5, 0, 0, 0, 0);
    // R4: saturation with two lanes per cycle
    for (int j = 0; j < 10; j++) step(1, 7, 9, 1, 7, 9, j == 9);
    check(histOut[79*4 +: 4] == 4'd15, "R4", "saturated cell", histOut[79*4 +: 4], 15);
    check(histOut[55*4 +: 4] == 4'd1, "R5", "post-strobe vote kept", histOut[55*4 +: 4], 1);
    checkHist("R4", "saturation image");
    checkEdges("R8");

    // R10: invalid lanes with any coordinates
    step(0, 20, 12, 0, 2, 2, 0);
    step(0, 31, 31, 0, 0, 9, 1);
    check(errCount == 0, "R10", "errCount unchanged", errCount, 0);
    checkHist("R10", "no cells touched");

    // R7: out-of-range sweep on both lanes
    for (int j = 0; j < 140; j++) begin
      step(1, 16 + j % 16, j % 10, 1, j % 16, 10 + j % 22, j == 139);
      if (j == 0)  check(int'(errCount) == errM, "R7", "per-cycle increment", errCount, errM);
      if (j == 49) check(int'(errCount) == errM, "R7", "count mid-sweep", errCount, errM);
    end
    check(int'(errCount) == EMAXV, "R7", "saturated errCount", errCount, EMAXV);
    checkHist("R7", "dropped segments touch no cell");
    // R7: mixed lane, one good one bad, at saturation
    step(1, 1, 1, 1, 17, 1, 1);
    check(int'(errCount) == EMAXV, "R7", "errCount held at max", errCount, EMAXV);
    checkHist("R7", "good lane alongside bad");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule